// File: doc/BRIEF.md
# Supervisory Reset and Watchdog Generator

This block supervises a processor. It holds a single reset line active while the supply is below its threshold. Once the supply recovers it keeps the line active for a fixed stretch, and it also keeps the line active for that same stretch after the processor fails to service a watchdog in time. A comparator outside the block provides a synchronous flag that reads high when the supply is above the reset threshold. The processor services the watchdog by toggling a watchdog input in either direction. A second input marks that watchdog pin as left unconnected, and while it is high no timeout can occur.

The pulse width and the watchdog interval are parameters counted in clock cycles, so a bench can run them scaled down. In a real design they are set near 0.2 s and 1.6 s. A parameter sets the active level of the output. After a simulation reset the line comes up active and then follows the power-up rule.

Top module: `sup_reset_gen`

## Requirements
- R1: While `rst_n` is low the output is active. After `rst_n` is released, the output stays active until `supply_ok` has been sampled high on RST_CYCLES consecutive rising clock edges, and it goes inactive at the last of those edges.
- R2: A low `supply_ok` sampled at a clock edge makes the output active at that edge. It stays active while the flag is low and is released exactly RST_CYCLES edges after the flag is again sampled high.
- R3: With ACTIVE_HIGH = 1 the output is 1 when active and 0 when inactive. With ACTIVE_HIGH = 0 these levels are inverted.
- R4: With the output inactive, `wdi` unchanged and `wdi_float` low, the output turns active on the WDT_CYCLES-th edge after it went inactive. It never turns active sooner than that from the watchdog.
- R5: With `wdi` held at a constant level, the output alternates between RST_CYCLES cycles active and WDT_CYCLES cycles inactive.
- R6: A rising or falling change of `wdi` first sampled at edge T restarts the interval at edge T+2, after passing through two synchronizing registers. The next timeout then lands at edge T+2+WDT_CYCLES.
- R7: While `wdi_float` is high, no watchdog timeout occurs. After it drops, a full WDT_CYCLES interval runs before a timeout.
- R8: The watchdog count is held at zero while the output is active for any cause, and it counts from zero starting at the edge after release.
- R9: A supply drop during a watchdog pulse extends the active period until RST_CYCLES edges after the supply is seen high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low simulation reset; the output comes up active |
| supply_ok | input | 1 | Synchronous flag, high when the supply is above the reset threshold |
| wdi | input | 1 | Watchdog service input; any transition services it |
| wdi_float | input | 1 | High when the watchdog pin is unconnected; suppresses timeouts |
| reset_out | output | 1 | Reset line, active level set by ACTIVE_HIGH |

## Verification
The bench sweeps where a `wdi` toggle falls inside the interval, right up to two cycles before the timeout. A design that skipped the synchronizer delay, or that serviced only one edge direction, would fire at the wrong cycle. Supply dips are injected both during a watchdog pulse and while the output is idle. A design that let the pulse counter run on while the supply was low would release too early. The run lengths of a stuck watchdog are measured over several periods, and those measurements expose a counter that kept counting through reset or was off by one. Both polarities run side by side on the same stimulus.

// File: rtl/sup_pkg.sv
package sup_pkg;

    // Bits needed to hold the values 0 .. n-1.
    function automatic int unsigned cnt_bits(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

    // Synchronizer stages plus the previous sample kept for edge detection.
    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } sync_t;

endpackage

// File: rtl/sup_wdi_sync.sv
module sup_wdi_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic wdi_i,
    output logic toggle_o
);
    import sup_pkg::*;

    sync_t q, d;

    always_comb begin
        d.s1     = wdi_i;
        d.s2     = q.s1;
        d.s3     = q.s2;
        toggle_o = q.s2 ^ q.s3;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/sup_wdt_timer.sv
module sup_wdt_timer #(
    parameter int unsigned WDT_CYCLES = 16,
    localparam int unsigned W = sup_pkg::cnt_bits(WDT_CYCLES)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hold_i,
    input  logic         kick_i,
    input  logic         float_i,
    output logic         fire_o,
    output logic [W-1:0] cnt_o
);
    localparam logic [W-1:0] LAST = W'(WDT_CYCLES - 1);

    typedef struct packed {
        logic [W-1:0] cnt;
    } wdt_t;

    wdt_t q, d;

    always_comb begin
        d      = q;
        fire_o = 1'b0;
        if (hold_i || kick_i || float_i) begin
            d.cnt = '0;
        end else if (q.cnt == LAST) begin
            fire_o = 1'b1;
            d.cnt  = '0;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cnt_o = q.cnt;
endmodule

// File: rtl/sup_rst_timer.sv
module sup_rst_timer #(
    parameter int unsigned RST_CYCLES = 8,
    localparam int unsigned W = sup_pkg::cnt_bits(RST_CYCLES)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok_i,
    input  logic trig_i,
    output logic active_o
);
    localparam logic [W-1:0] LAST = W'(RST_CYCLES - 1);

    typedef struct packed {
        logic         active;
        logic [W-1:0] cnt;
    } rst_t;

    rst_t q, d;

    always_comb begin
        d = q;
        if (!supply_ok_i) begin
            // Low supply wins over everything and restarts the stretch.
            d.active = 1'b1;
            d.cnt    = '0;
        end else if (q.active) begin
            if (q.cnt == LAST) begin
                d.active = 1'b0;
                d.cnt    = '0;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end else if (trig_i) begin
            d.active = 1'b1;
            d.cnt    = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.active <= 1'b1;
            q.cnt    <= '0;
        end else begin
            q <= d;
        end
    end

    assign active_o = q.active;
endmodule

// File: rtl/sup_reset_gen.sv
module sup_reset_gen #(
    parameter int unsigned RST_CYCLES  = 40_000_000,
    parameter int unsigned WDT_CYCLES  = 320_000_000,
    parameter bit          ACTIVE_HIGH = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic wdi,
    input  logic wdi_float,
    output logic reset_out
);
    localparam int unsigned WW = sup_pkg::cnt_bits(WDT_CYCLES);

    logic          kick;
    logic          fire;
    logic          active;
    logic [WW-1:0] wdt_cnt;

    sup_wdi_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .wdi_i    (wdi),
        .toggle_o (kick)
    );

    sup_wdt_timer #(.WDT_CYCLES(WDT_CYCLES)) u_wdt (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold_i  (active),
        .kick_i  (kick),
        .float_i (wdi_float),
        .fire_o  (fire),
        .cnt_o   (wdt_cnt)
    );

    sup_rst_timer #(.RST_CYCLES(RST_CYCLES)) u_rst (
        .clk         (clk),
        .rst_n       (rst_n),
        .supply_ok_i (supply_ok),
        .trig_i      (fire),
        .active_o    (active)
    );

    generate
        if (ACTIVE_HIGH) begin : g_pol_hi
            assign reset_out = active;
        end else begin : g_pol_lo
            assign reset_out = ~active;
        end
    endgenerate
endmodule

// File: rtl/sup_reset_gen_chk.sv
module sup_reset_gen_chk #(
    parameter int unsigned RST_CYCLES  = 8,
    parameter int unsigned WDT_CYCLES  = 16,
    parameter bit          ACTIVE_HIGH = 1'b0,
    localparam int unsigned WW = sup_pkg::cnt_bits(WDT_CYCLES)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          supply_ok,
    input logic          wdi_float,
    input logic          reset_out,
    input logic [WW-1:0] wdt_cnt
);
    logic        asserted;
    logic [31:0] run_q;
    logic [31:0] idle_q;

    assign asserted = (reset_out == ACTIVE_HIGH);

    // Edges seen active with supply high, and edges seen idle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q  <= '0;
            idle_q <= '0;
        end else begin
            if (!supply_ok || !asserted) run_q <= '0;
            else if (run_q != 32'hFFFF_FFFF) run_q <= run_q + 1;
            if (asserted || wdi_float) idle_q <= '0;
            else if (idle_q != 32'hFFFF_FFFF) idle_q <= idle_q + 1;
        end
    end

    p_full_width_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(asserted) |-> run_q == RST_CYCLES);

    p_low_supply_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> asserted);

    p_no_early_fire_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(asserted) && $past(supply_ok)) |-> idle_q >= WDT_CYCLES);

    p_float_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wdi_float && supply_ok && !asserted) |=> !asserted);

    p_wdt_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        asserted |=> wdt_cnt == '0);
endmodule

bind sup_reset_gen sup_reset_gen_chk #(
    .RST_CYCLES (RST_CYCLES),
    .WDT_CYCLES (WDT_CYCLES),
    .ACTIVE_HIGH(ACTIVE_HIGH)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .supply_ok (supply_ok),
    .wdi_float (wdi_float),
    .reset_out (reset_out),
    .wdt_cnt   (wdt_cnt)
);

// File: tb/tb_sup_reset_gen.sv
`timescale 1ns/1ps
module tb_sup_reset_gen;
    localparam int unsigned RST = 5;
    localparam int unsigned WDT = 12;

    logic clk = 1'b0;
    logic rst_n, supply_ok, wdi, wdi_float;
    logic out_l, out_h;
    int   checks = 0;
    int   fails  = 0;

    always #2.5 clk = ~clk;

    sup_reset_gen #(.RST_CYCLES(RST), .WDT_CYCLES(WDT), .ACTIVE_HIGH(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .wdi(wdi),
        .wdi_float(wdi_float), .reset_out(out_l));

    sup_reset_gen #(.RST_CYCLES(RST), .WDT_CYCLES(WDT), .ACTIVE_HIGH(1'b1)) dut_h (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .wdi(wdi),
        .wdi_float(wdi_float), .reset_out(out_h));

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Both polarities checked together (R3).
    task automatic chk(input bit exp, input string req);
        checks++;
        if (out_h !== exp || out_l !== !exp) begin
            fails++;
            $display("FAIL %s (R3 pair): out_h=%b out_l=%b, expected active=%b",
                     req, out_h, out_l, exp);
        end
    endtask

    task automatic chk_int(input int act, input int exp, input string req);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d, expected %0d", req, act, exp);
        end
    endtask

    // Length of the current level run, counting the tick that began it.
    task automatic run_len(input logic level, output int n);
        n = 1;
        for (int g = 0; g < 1000; g++) begin
            tick();
            if (out_h == level) n++;
            else break;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int n;
        rst_n = 1'b0; supply_ok = 1'b1; wdi = 1'b0; wdi_float = 1'b0;
        @(negedge clk);
        repeat (3) tick();
        chk(1'b1, "R1 reset state");
        rst_n = 1'b1;

        // R1: power-up stretch
        for (int i = 1; i <= RST + 1; i++) begin
            tick();
            chk(i < RST, "R1 power-up width");
        end
        // R4: first timeout after release (tick 1 already done)
        for (int j = 2; j <= WDT; j++) begin
            tick();
            chk(j >= WDT, "R4 timeout edge");
        end

        // R5: stuck input repeats
        for (int p = 0; p < 3; p++) begin
            run_len(1'b1, n);
            chk_int(n, RST, "R5 active run");
            run_len(1'b0, n);
            chk_int(n, WDT, "R5 idle run");
        end

        // R6: toggle position sweep, both edge directions alternate
        for (int k = 1; k <= WDT - 2; k++) begin
            run_len(1'b1, n);
            chk_int(n, RST, "R6 pulse before sweep");
            for (int t = 1; t <= k + 2 + WDT; t++) begin
                if (t == k) wdi = ~wdi;
                tick();
                chk(t >= k + 2 + WDT, "R6 restart on toggle");
            end
        end

        // R9 / R2 / R8: supply dips of several lengths
        for (int len = 1; len <= 3; len++) begin
            for (int m = 0; m < len; m++) begin
                tick();
                chk(1'b1, "R9 pulse ongoing");
            end
            supply_ok = 1'b0;
            for (int m = 0; m < len; m++) begin
                tick();
                chk(1'b1, "R9 held while low");
            end
            supply_ok = 1'b1;
            for (int i = 1; i <= RST; i++) begin
                tick();
                chk(i < RST, "R9 extended release");
            end
            repeat (2) tick();
            chk(1'b0, "R2 idle before dip");
            supply_ok = 1'b0;
            tick();
            chk(1'b1, "R2 brown-out assert");
            for (int m = 0; m < len; m++) begin
                tick();
                chk(1'b1, "R2 held while low");
            end
            supply_ok = 1'b1;
            for (int i = 1; i <= RST; i++) begin
                tick();
                chk(i < RST, "R2 release after recovery");
            end
            for (int j = 1; j <= WDT; j++) begin
                tick();
                chk(j >= WDT, "R8 count restarts from zero");
            end
        end

        // R7: floating watchdog pin
        run_len(1'b1, n);
        chk_int(n, RST, "R7 pulse before float");
        wdi_float = 1'b1;
        for (int t = 1; t <= 3 * WDT; t++) begin
            tick();
            chk(1'b0, "R7 no timeout while floating");
        end
        wdi_float = 1'b0;
        for (int j = 1; j <= WDT; j++) begin
            tick();
            chk(j >= WDT, "R7 full interval after float");
        end

        // R1: power-up with supply initially low
        rst_n = 1'b0; supply_ok = 1'b0;
        tick();
        rst_n = 1'b1;
        for (int m = 0; m < 4; m++) begin
            tick();
            chk(1'b1, "R1 held while supply low");
        end
        supply_ok = 1'b1;
        for (int i = 1; i <= RST; i++) begin
            tick();
            chk(i < RST, "R1 stretch after supply rise");
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule